// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block caches recent virtual-to-physical page translations. Every entry is compared against an incoming virtual page number at the same time (fully associative). Each entry carries an address space number (ASN) next to its virtual page number, so translations belonging to different processes can sit side by side and a context switch needs no flush. Each entry also holds three permission bits that are checked against the kind of access being made.

A requester presents a virtual page number, the current ASN, the access kind and the page offset. One cycle later the block reports a hit, a miss or a protection fault. On a hit it returns the physical address, formed from the stored physical page number with the unchanged offset appended. Walking the page table is left to the requester: a miss is only reported. The requester then installs the translation through a refill port. A refill goes to a free entry if one exists, and otherwise replaces the least recently used entry under true LRU order. Two invalidate inputs clear either every entry or every entry of one ASN.

Top module: `asn_tlb`

## Requirements
- R1: After reset every entry is invalid, res_valid, res_hit and res_fault are 0, and the replacement order runs from entry 0 (most recent) to entry N_ENT-1 (least recent).
- R2: A lookup accepted on one clock edge is answered on the next edge: res_valid equals the previous cycle's lk_valid. An entry matches only when it is valid and both its page number and its ASN equal the request.
- R3: On a hit, res_paddr is the matching entry's physical page number in the upper bits with lk_ofs in the low OFS_W bits. When there is no hit, res_paddr is 0.
- R4: Permission bit 0 allows read, bit 1 allows write and bit 2 allows execute. lk_acc code 0 is read, 1 is write, 2 is execute, and 3 is reserved and never allowed. A matching entry whose bit for the access is clear gives res_fault=1 and res_hit=0.
- R5: A refill writes the lowest-numbered invalid entry if there is one, and otherwise the least recently used entry.
- R6: A hit and a refill each make the touched entry the most recently used. A miss and a fault leave the order unchanged.
- R7: When a refill and a lookup fall in the same cycle, the lookup is answered from the contents before the refill, and only the refill updates the replacement order.
- R8: inv_asn_en invalidates every entry whose ASN equals inv_asn. inv_all invalidates every entry. Invalidation is applied after a refill in the same cycle, and a lookup in that cycle sees the contents from before the invalidation.
- R9: Two entries with the same virtual page number and different ASNs coexist, and each is returned only to its own ASN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asn | input | ASN_W | Address space number of the requester |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| lk_ofs | input | OFS_W | Page offset passed through to the physical address |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Virtual page number of the new translation |
| fill_asn | input | ASN_W | ASN of the new translation |
| fill_ppn | input | PPN_W | Physical page number of the new translation |
| fill_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| inv_asn_en | input | 1 | Invalidate all entries of one ASN |
| inv_asn | input | ASN_W | ASN to invalidate |
| inv_all | input | 1 | Invalidate every entry |
| res_valid | output | 1 | Lookup answer present |
| res_hit | output | 1 | Translation found and access allowed |
| res_fault | output | 1 | Translation found but access not allowed |
| res_paddr | output | PPN_W+OFS_W | Physical address on a hit, else 0 |

## Verification
The assertions assume that the requester never installs a translation whose page number and ASN pair is already resident. Under that assumption no two valid entries can match the same lookup, and the one-hot match check depends on it. The directed sequences refill only after a miss or an invalidation. The randomized phase looks up the reference model's contents and refills a pair only when it is absent. The assertions also assume that the access code and the permission bits are fully driven every cycle, which the bench does by holding every input at a defined value, including during reset.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_RSV = 2'd3
    } acc_e;

    localparam int PERM_W = 3;

    // bit 0 read, bit 1 write, bit 2 execute; reserved code never allowed
    function automatic logic perm_allows(input logic [PERM_W-1:0] perm,
                                         input logic [1:0] acc);
        logic ok;
        case (acc_e'(acc))
            ACC_RD:  ok = perm[0];
            ACC_WR:  ok = perm[1];
            ACC_EX:  ok = perm[2];
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int N     = 128,
    parameter int VPN_W = 20,
    parameter int ASN_W = 8
) (
    input  logic [N-1:0]            ent_valid,
    input  logic [N-1:0][VPN_W-1:0] ent_vpn,
    input  logic [N-1:0][ASN_W-1:0] ent_asn,
    input  logic [VPN_W-1:0]        key_vpn,
    input  logic [ASN_W-1:0]        key_asn,
    output logic [N-1:0]            hit_vec
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = ent_valid[g]
                          && (ent_vpn[g] == key_vpn)
                          && (ent_asn[g] == key_asn);
    end

endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
    parameter int N = 128,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);

    // lowest set index wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int N = 128,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch_en,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] lru_idx
);

    // rank 0 = most recent, rank N-1 = least recent
    typedef struct packed {
        logic [N-1:0][IW-1:0] rank;
    } lru_t;

    lru_t st_d, st_q;
    logic [N-1:0] oldest_vec;

    always_comb begin
        st_d = st_q;
        if (touch_en) begin
            for (int i = 0; i < N; i++) begin
                if (st_q.rank[i] < st_q.rank[touch_idx])
                    st_d.rank[i] = st_q.rank[i] + 1'b1;
            end
            st_d.rank[touch_idx] = '0;
        end
    end

    always_comb begin
        lru_idx = '0;
        for (int i = 0; i < N; i++) begin
            oldest_vec[i] = (st_q.rank[i] == IW'(N - 1));
            if (oldest_vec[i])
                lru_idx = IW'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++)
                st_q.rank[i] <= IW'(i);
        end else begin
            st_q <= st_d;
        end
    end

    // R6
    lru_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(oldest_vec));

endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
    import tlb_pkg::*;
#(
    parameter int N_ENT = 128,
    parameter int VPN_W = 20,
    parameter int PPN_W = 16,
    parameter int ASN_W = 8,
    parameter int OFS_W = 12,
    localparam int IDX_W = $clog2(N_ENT),
    localparam int PA_W  = PPN_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASN_W-1:0]  lk_asn,
    input  logic [1:0]        lk_acc,
    input  logic [OFS_W-1:0]  lk_ofs,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASN_W-1:0]  fill_asn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [2:0]        fill_perm,
    input  logic              inv_asn_en,
    input  logic [ASN_W-1:0]  inv_asn,
    input  logic              inv_all,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_fault,
    output logic [PA_W-1:0]   res_paddr
);

    typedef struct packed {
        logic [N_ENT-1:0]             valid;
        logic [N_ENT-1:0][VPN_W-1:0]  vpn;
        logic [N_ENT-1:0][ASN_W-1:0]  asn;
        logic [N_ENT-1:0][PPN_W-1:0]  ppn;
        logic [N_ENT-1:0][PERM_W-1:0] perm;
        logic                         rv;
        logic                         rh;
        logic                         rf;
        logic [PA_W-1:0]              pa;
    } st_t;

    st_t st_d, st_q;

    logic [N_ENT-1:0] hit_vec;
    logic             hit_found;
    logic [IDX_W-1:0] hit_idx;
    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] lru_idx;
    logic [IDX_W-1:0] victim;
    logic             acc_ok;
    logic             touch_en;
    logic [IDX_W-1:0] touch_idx;

    tlb_cam #(.N(N_ENT), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_cam (
        .ent_valid (st_q.valid),
        .ent_vpn   (st_q.vpn),
        .ent_asn   (st_q.asn),
        .key_vpn   (lk_vpn),
        .key_asn   (lk_asn),
        .hit_vec   (hit_vec)
    );

    tlb_pick #(.N(N_ENT)) u_hit_pick (
        .vec   (hit_vec),
        .found (hit_found),
        .idx   (hit_idx)
    );

    tlb_pick #(.N(N_ENT)) u_free_pick (
        .vec   (~st_q.valid),
        .found (free_found),
        .idx   (free_idx)
    );

    tlb_lru #(.N(N_ENT)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .lru_idx   (lru_idx)
    );

    assign acc_ok    = hit_found && perm_allows(st_q.perm[hit_idx], lk_acc);
    assign victim    = free_found ? free_idx : lru_idx;
    // a refill owns the order update; a same-cycle lookup hit does not touch
    assign touch_en  = fill_valid || (lk_valid && acc_ok);
    assign touch_idx = fill_valid ? victim : hit_idx;

    always_comb begin
        st_d    = st_q;
        // answer from the contents held before this edge
        st_d.rv = lk_valid;
        st_d.rh = lk_valid && acc_ok;
        st_d.rf = lk_valid && hit_found && !acc_ok;
        st_d.pa = (lk_valid && acc_ok) ? {st_q.ppn[hit_idx], lk_ofs} : '0;

        if (fill_valid) begin
            st_d.valid[victim] = 1'b1;
            st_d.vpn[victim]   = fill_vpn;
            st_d.asn[victim]   = fill_asn;
            st_d.ppn[victim]   = fill_ppn;
            st_d.perm[victim]  = fill_perm;
        end

        // invalidation lands after any refill of the same cycle
        if (inv_all) begin
            st_d.valid = '0;
        end else if (inv_asn_en) begin
            for (int i = 0; i < N_ENT; i++) begin
                if (st_d.asn[i] == inv_asn)
                    st_d.valid[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign res_valid = st_q.rv;
    assign res_hit   = st_q.rh;
    assign res_fault = st_q.rf;
    assign res_paddr = st_q.pa;

    // R2
    hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R2
    res_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    // R4
    hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_hit && res_fault));

    // R3
    miss_paddr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> (res_paddr == '0));

    // R8
    inv_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (st_q.valid == '0));

endmodule

// File: tb/sim_asn_tlb.sv
module sim_asn_tlb;

    localparam int N     = 8;
    localparam int VPN_W = 8;
    localparam int PPN_W = 8;
    localparam int ASN_W = 4;
    localparam int OFS_W = 4;
    localparam int PA_W  = PPN_W + OFS_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 1'b0;
    logic [VPN_W-1:0] lk_vpn = '0;
    logic [ASN_W-1:0] lk_asn = '0;
    logic [1:0] lk_acc = '0;
    logic [OFS_W-1:0] lk_ofs = '0;
    logic fill_valid = 1'b0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [ASN_W-1:0] fill_asn = '0;
    logic [PPN_W-1:0] fill_ppn = '0;
    logic [2:0] fill_perm = '0;
    logic inv_asn_en = 1'b0;
    logic [ASN_W-1:0] inv_asn = '0;
    logic inv_all = 1'b0;
    logic res_valid, res_hit, res_fault;
    logic [PA_W-1:0] res_paddr;

    always #5 clk = ~clk;

    asn_tlb #(.N_ENT(N), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W),
              .OFS_W(OFS_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asn(lk_asn),
        .lk_acc(lk_acc), .lk_ofs(lk_ofs),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asn(fill_asn),
        .fill_ppn(fill_ppn), .fill_perm(fill_perm),
        .inv_asn_en(inv_asn_en), .inv_asn(inv_asn), .inv_all(inv_all),
        .res_valid(res_valid), .res_hit(res_hit), .res_fault(res_fault),
        .res_paddr(res_paddr)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit cmp_on = 0;
    string cur_req = "R1";

    // ---------------- behavioural reference ----------------
    bit m_v [N];
    int m_vpn [N];
    int m_asn [N];
    int m_ppn [N];
    int m_perm [N];
    int order [$];          // front = most recent
    bit e_rv, e_rh, e_rf;
    int e_pa;

    function automatic bit allowed(int perm, int acc);
        if (acc == 0) return perm[0];
        if (acc == 1) return perm[1];
        if (acc == 2) return perm[2];
        return 0;
    endfunction

    function automatic void promote(int k);
        for (int j = 0; j < order.size(); j++) begin
            if (order[j] == k) begin
                order.delete(j);
                break;
            end
        end
        order.push_front(k);
    endfunction

    function automatic bit resident(int vpn, int asn);
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_vpn[i] == vpn && m_asn[i] == asn) return 1;
        return 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            order.delete();
            for (int i = 0; i < N; i++) begin
                m_v[i] = 0;
                order.push_back(i);
            end
            e_rv = 0; e_rh = 0; e_rf = 0; e_pa = 0;
        end else begin
            int k;
            int victim;
            k = -1;
            for (int i = 0; i < N; i++)
                if (m_v[i] && m_vpn[i] == int'(lk_vpn) && m_asn[i] == int'(lk_asn))
                    k = i;
            e_rv = lk_valid;
            e_rh = lk_valid && k >= 0 && allowed(m_perm[k], int'(lk_acc));
            e_rf = lk_valid && k >= 0 && !allowed(m_perm[k], int'(lk_acc));
            e_pa = e_rh ? (m_ppn[k] * (1 << OFS_W) + int'(lk_ofs)) : 0;
            if (fill_valid) begin
                victim = -1;
                for (int i = N - 1; i >= 0; i--)
                    if (!m_v[i]) victim = i;
                if (victim < 0) victim = order[$];
                m_v[victim] = 1;
                m_vpn[victim] = int'(fill_vpn);
                m_asn[victim] = int'(fill_asn);
                m_ppn[victim] = int'(fill_ppn);
                m_perm[victim] = int'(fill_perm);
                promote(victim);
            end else if (e_rh) begin
                promote(k);
            end
            if (inv_all) begin
                for (int i = 0; i < N; i++) m_v[i] = 0;
            end else if (inv_asn_en) begin
                for (int i = 0; i < N; i++)
                    if (m_asn[i] == int'(inv_asn)) m_v[i] = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            total++;
            if (res_valid !== e_rv || res_hit !== e_rh || res_fault !== e_rf ||
                res_paddr !== PA_W'(e_pa)) begin
                bad++;
                $display("FAIL %s actual v=%0b h=%0b f=%0b pa=%0h expected v=%0b h=%0b f=%0b pa=%0h",
                         cur_req, res_valid, res_hit, res_fault, res_paddr,
                         e_rv, e_rh, e_rf, e_pa[PA_W-1:0]);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(negedge clk);
        lk_valid = 0; fill_valid = 0; inv_asn_en = 0; inv_all = 0;
    endtask

    task automatic set_lk(int vpn, int asn, int acc, int ofs);
        lk_valid = 1; lk_vpn = VPN_W'(vpn); lk_asn = ASN_W'(asn);
        lk_acc = 2'(acc); lk_ofs = OFS_W'(ofs);
    endtask

    task automatic set_fill(int vpn, int asn, int ppn, int perm);
        fill_valid = 1; fill_vpn = VPN_W'(vpn); fill_asn = ASN_W'(asn);
        fill_ppn = PPN_W'(ppn); fill_perm = 3'(perm);
    endtask

    task automatic lookup(int vpn, int asn, int acc, int ofs);
        set_lk(vpn, asn, acc, ofs); tick();
    endtask

    task automatic fill(int vpn, int asn, int ppn, int perm);
        set_fill(vpn, asn, ppn, perm); tick();
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        total++;
        if (res_valid !== 0 || res_hit !== 0 || res_fault !== 0) begin
            bad++;
            $display("FAIL R1 reset outputs actual=%0b%0b%0b expected=000",
                     res_valid, res_hit, res_fault);
        end
        rst_n = 1;
        cmp_on = 1;
        tick();

        cur_req = "R1";
        lookup(5, 1, 0, 3);
        tick();

        // R2 R3: fill all entries, look each up
        cur_req = "R2";
        for (int i = 0; i < N; i++) fill(16 + i, 1, 64 + i, 7);
        cur_req = "R3";
        for (int i = 0; i < N; i++) lookup(16 + i, 1, i % 3, i + 1);
        lookup(16, 2, 0, 0);
        lookup(99, 1, 0, 0);

        // R6: reorder, then full-table refills evict by age
        cur_req = "R6";
        lookup(16 + 3, 1, 0, 0);
        lookup(16 + 0, 1, 0, 0);
        lookup(16 + 5, 1, 3, 0);     // fault: no promotion
        fill(40, 1, 200, 7);
        fill(41, 1, 201, 7);
        for (int i = 0; i < N; i++) lookup(16 + i, 1, 0, 2);
        lookup(40, 1, 0, 1);
        lookup(41, 1, 0, 1);

        // R9: same page, other ASN
        cur_req = "R9";
        fill(16 + 3, 2, 150, 7);
        lookup(16 + 3, 2, 0, 4);
        lookup(16 + 3, 1, 0, 4);

        // R4: permission combinations
        cur_req = "R4";
        tick();
        inv_all = 1; tick();
        fill(1, 3, 11, 1);
        fill(2, 3, 12, 2);
        fill(3, 3, 13, 4);
        fill(4, 3, 14, 0);
        for (int v = 1; v <= 4; v++)
            for (int a = 0; a < 4; a++) lookup(v, 3, a, 5);

        // R5: hole gets filled before the oldest entry
        cur_req = "R5";
        fill(5, 4, 15, 7);
        fill(6, 4, 16, 7);
        fill(7, 5, 17, 7);
        fill(8, 5, 18, 7);
        inv_asn_en = 1; inv_asn = 4; tick();
        fill(9, 6, 19, 7);
        for (int v = 1; v <= 9; v++) lookup(v, v < 5 ? 3 : (v < 7 ? 4 : (v < 9 ? 5 : 6)), 0, 0);

        // R7: refill and lookup in one cycle
        cur_req = "R7";
        set_lk(50, 7, 0, 1); set_fill(50, 7, 77, 7); tick();
        lookup(50, 7, 0, 1);
        set_lk(1, 3, 0, 2); set_fill(51, 7, 78, 7); tick();
        fill(52, 7, 79, 7);
        lookup(1, 3, 0, 2);
        lookup(7, 5, 0, 2);

        // R8: invalidation ordering
        cur_req = "R8";
        set_lk(50, 7, 0, 6); inv_asn_en = 1; inv_asn = 7; tick();
        lookup(50, 7, 0, 6);
        lookup(51, 7, 0, 6);
        set_fill(60, 8, 90, 7); inv_asn_en = 1; inv_asn = 8; tick();
        lookup(60, 8, 0, 0);
        set_fill(61, 9, 91, 7); inv_all = 1; tick();
        lookup(61, 9, 0, 0);
        lookup(9, 6, 0, 0);

        // mixed traffic
        cur_req = "R6";
        for (int n = 0; n < 600; n++) begin
            int vpn, asn;
            vpn = int'($urandom_range(0, 11));
            asn = int'($urandom_range(0, 2));
            set_lk(int'($urandom_range(0, 11)), int'($urandom_range(0, 2)),
                   int'($urandom_range(0, 3)), int'($urandom_range(0, 15)));
            if ($urandom_range(0, 2) == 0 && !resident(vpn, asn))
                set_fill(vpn, asn, int'($urandom_range(0, 255)),
                         int'($urandom_range(0, 7)));
            if ($urandom_range(0, 40) == 0) begin
                inv_asn_en = 1; inv_asn = ASN_W'($urandom_range(0, 2));
            end
            if ($urandom_range(0, 150) == 0) inv_all = 1;
            tick();
        end
        tick();

        done = 1;
        summary();
        $finish;
    end

endmodule